// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a shared, single-wire serial interrupt bus. It opens each polling cycle with a start frame and then walks 21 data frames. Each data frame gives one interrupt source a sample slot. The block closes the cycle with a stop frame whose low time tells every peripheral how the next cycle will begin. The wire is open-drain. The block senses it through `line_in` and can pull it low (`line_drive_low`) or push it high for one recovery clock (`line_drive_high`). The pull-up resistor is outside the block.

The cycle can begin in two ways. In continuous mode the host starts every cycle on its own, with a start frame of 4, 6 or 8 clocks. In quiet mode the wire stays idle until a peripheral pulls it low for one clock. The host then holds it low for the rest of the start frame.

Decoded levels are always presented as "1 = requested", whatever the polarity of the wire for that source. They change only when a full cycle completes. The outputs are level registers with no handshake, so there is no back-pressure: a consumer reads `irq_level` whenever it likes and always sees the last complete cycle.

Top module: `serint_host`

## Requirements
- R1: While `enable` is low or reset is active, the host drives nothing, `mode_quiet` reads 0, and reset clears `irq_level`. One clock after `enable` rises, the host starts a start frame on its own, in continuous mode.
- R2: In continuous mode the start frame holds the line low for a number of clocks set by `width_sel`: 00 gives 4, 01 gives 6, 10 gives 8, and 11 gives 4.
- R3: In quiet mode the host releases the line after the stop frame and drives nothing until it senses `line_in` low. After that it drives low for one clock fewer than the width in R2.
- R4: After the start frame come one recovery clock and one turnaround clock. Then 21 data frames follow, each of 3 clocks in the order sample, recovery, turnaround. The line is read in the sample clock. Frame k feeds `irq_level[k]`.
- R5: Frames 0, 1 and 3 to 15 carry active-high sources: a high sample gives level 1 and a low sample gives level 0.
- R6: Frame 2 (SMI#) and frames 16 (IOCHK#) and 17 to 20 (INTA# to INTD#) carry active-low sources: a low sample gives level 1.
- R7: The stop frame holds the line low for 2 clocks when `quiet_sel` is 1 at the end of frame 20, and for 3 clocks otherwise. `mode_quiet` takes that choice after the stop frame's turnaround clock.
- R8: Every low drive by the host is followed by exactly one clock of high drive, and then the host releases the line. The host never drives low and high together.
- R9: `irq_level` changes only in the first clock of a stop frame. A cycle cut short by disable or reset leaves the previous levels in place (disable) or cleared to 0 (reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the polling cycles; low aborts and releases the line |
| width_sel | input | 2 | Start-frame width code |
| quiet_sel | input | 1 | Mode requested for the next cycle (1 = quiet) |
| line_in | input | 1 | Sensed level of the shared wire |
| line_drive_low | output | 1 | Pull the wire low |
| line_drive_high | output | 1 | Drive the wire high (recovery) |
| irq_level | output | 21 | Decoded request per frame, 1 = requested |
| mode_quiet | output | 1 | Current mode, 1 = quiet |

## Verification
The hardest situation to reach from the ports is a cycle aborted in quiet mode, midway through the data frames. The bench reaches it with a peripheral model that follows the wire's recovery edge to time its samples. The model first steers a stop frame into quiet mode, then issues the one-clock wake-up pull, and drops `enable` at frame 6 of the following cycle. It then checks that the old levels survive, that the mode falls back to continuous, and that the next start frame is host-initiated at full width. The shortened quiet start frame is checked the same way, by counting the host's low clocks after the peripheral's pull.

// File: rtl/serint_pkg.sv
package serint_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_START, ST_START_REC, ST_START_TA,
    ST_DATA, ST_STOP, ST_STOP_REC, ST_STOP_TA
  } seq_state_t;

  typedef enum logic {MODE_CONT = 1'b0, MODE_QUIET = 1'b1} bus_mode_t;

  localparam int CNT_W = 4;

  // Start-frame width from the 2-bit code; the reserved code falls back to 4.
  function automatic logic [CNT_W-1:0] start_width(input logic [1:0] code);
    case (code)
      2'b01:   return CNT_W'(6);
      2'b10:   return CNT_W'(8);
      default: return CNT_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/serint_seq.sv
module serint_seq
  import serint_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3,
  localparam int FW = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    width_sel,
  input  logic          quiet_sel,
  input  logic          line_in,
  output seq_state_t    state,
  output bus_mode_t     mode,
  output logic          sample_en,
  output logic [FW-1:0] frame_idx,
  output logic          seq_done
);
  logic [CNT_W-1:0] cnt;
  logic [1:0]       phase;
  bus_mode_t        next_mode;
  logic             last_frame;

  assign last_frame = (frame_idx == FW'(NUM_FRAMES - 1));
  assign sample_en  = (state == ST_DATA) && (phase == 2'd0);
  assign seq_done   = (state == ST_DATA) && (phase == 2'd2) && last_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      phase     <= '0;
      frame_idx <= '0;
      mode      <= MODE_CONT;
      next_mode <= MODE_CONT;
    end else if (!enable) begin
      state <= ST_IDLE;
      mode  <= MODE_CONT;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_START;
          cnt   <= start_width(width_sel) - CNT_W'(1);
        end
        ST_WAIT: if (!line_in) begin
          // peripheral supplied the first low clock
          state <= ST_START;
          cnt   <= start_width(width_sel) - CNT_W'(2);
        end
        ST_START: if (cnt == '0) state <= ST_START_REC; else cnt <= cnt - CNT_W'(1);
        ST_START_REC: state <= ST_START_TA;
        ST_START_TA: begin
          state     <= ST_DATA;
          frame_idx <= '0;
          phase     <= '0;
        end
        ST_DATA: begin
          if (phase == 2'd2) begin
            phase <= '0;
            if (last_frame) begin
              state     <= ST_STOP;
              cnt       <= quiet_sel ? CNT_W'(STOP_QUIET - 1) : CNT_W'(STOP_CONT - 1);
              next_mode <= quiet_sel ? MODE_QUIET : MODE_CONT;
            end else begin
              frame_idx <= frame_idx + FW'(1);
            end
          end else begin
            phase <= phase + 2'd1;
          end
        end
        ST_STOP: if (cnt == '0) state <= ST_STOP_REC; else cnt <= cnt - CNT_W'(1);
        ST_STOP_REC: state <= ST_STOP_TA;
        ST_STOP_TA: begin
          mode <= next_mode;
          if (next_mode == MODE_QUIET) begin
            state <= ST_WAIT;
          end else begin
            state <= ST_START;
            cnt   <= start_width(width_sel) - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serint_capture.sv
module serint_capture #(
  parameter int NUM_FRAMES = 21,
  parameter logic [NUM_FRAMES-1:0] LOW_ACTIVE = 21'h1F0004,
  localparam int FW = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic [FW-1:0]         frame_idx,
  input  logic                  line_in,
  input  logic                  seq_done,
  output logic [NUM_FRAMES-1:0] levels
);
  logic [NUM_FRAMES-1:0] shadow;

  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow[k] <= 1'b0;
      else if (sample_en && frame_idx == FW'(k))
        shadow[k] <= LOW_ACTIVE[k] ? !line_in : line_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        levels <= '0;
    else if (seq_done) levels <= shadow;
  end
endmodule

// File: rtl/serint_drive.sv
module serint_drive
  import serint_pkg::*;
(
  input  seq_state_t state,
  output logic       drive_low,
  output logic       drive_high
);
  always_comb begin
    drive_low  = (state == ST_START) || (state == ST_STOP);
    drive_high = (state == ST_START_REC) || (state == ST_STOP_REC);
  end
endmodule

// File: rtl/serint_host.sv
module serint_host
  import serint_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter logic [NUM_FRAMES-1:0] LOW_ACTIVE = 21'h1F0004,
  parameter int STOP_QUIET = 2,
  parameter int STOP_CONT  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [1:0]            width_sel,
  input  logic                  quiet_sel,
  input  logic                  line_in,
  output logic                  line_drive_low,
  output logic                  line_drive_high,
  output logic [NUM_FRAMES-1:0] irq_level,
  output logic                  mode_quiet
);
  localparam int FW = $clog2(NUM_FRAMES);

  seq_state_t    state;
  bus_mode_t     mode;
  logic          sample_en;
  logic          seq_done;
  logic [FW-1:0] frame_idx;

  serint_seq #(
    .NUM_FRAMES(NUM_FRAMES), .STOP_QUIET(STOP_QUIET), .STOP_CONT(STOP_CONT)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_sel(width_sel),
    .quiet_sel(quiet_sel), .line_in(line_in), .state(state), .mode(mode),
    .sample_en(sample_en), .frame_idx(frame_idx), .seq_done(seq_done)
  );

  serint_capture #(.NUM_FRAMES(NUM_FRAMES), .LOW_ACTIVE(LOW_ACTIVE)) i_cap (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .frame_idx(frame_idx),
    .line_in(line_in), .seq_done(seq_done), .levels(irq_level)
  );

  serint_drive i_drv (
    .state(state), .drive_low(line_drive_low), .drive_high(line_drive_high)
  );

  assign mode_quiet = (mode == MODE_QUIET);
endmodule

// File: rtl/serint_host_chk.sv
module serint_host_chk #(parameter int NUM_FRAMES = 21) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable,
  input logic                  line_drive_low,
  input logic                  line_drive_high,
  input logic [NUM_FRAMES-1:0] irq_level
);
  assert_no_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_drive_low && line_drive_high));

  assert_low_then_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_drive_low) |-> line_drive_high);

  assert_high_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_high |=> !line_drive_high && !line_drive_low);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !line_drive_low && !line_drive_high);

  assert_levels_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_level) |-> line_drive_low && $past(!line_drive_low));
endmodule

bind serint_host serint_host_chk #(.NUM_FRAMES(NUM_FRAMES)) i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .line_drive_low(line_drive_low),
  .line_drive_high(line_drive_high), .irq_level(irq_level)
);

// File: tb/test_serint_host.sv
`timescale 1ns/1ps
module test_serint_host;
  localparam int NF = 21;
  localparam logic [NF-1:0] LOWMASK = 21'h1F0004;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, quiet_sel = 1'b0, periph_low = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic drv_low, drv_high, mode_q, line_in;
  logic [NF-1:0] levels;

  assign line_in = !(drv_low || periph_low);

  serint_host i_serint_host (
    .clk(clk), .rst_n(rst_n), .enable(enable), .width_sel(width_sel),
    .quiet_sel(quiet_sel), .line_in(line_in), .line_drive_low(drv_low),
    .line_drive_high(drv_high), .irq_level(levels), .mode_quiet(mode_q)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int bstate = 0, pos = 0, low_run = 0, start_len = 0, stop_len = 0, seq_count = 0, rel_cnt = 0;
  bit kick_en = 0;
  logic [NF-1:0] pattern = '0;

  localparam logic [1:0]    TW[4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int            TL[4] = '{4, 6, 8, 4};
  localparam logic [NF-1:0] TP[4] = '{21'h000000, 21'h1FFFFF, 21'h155555, 21'h0F0F0F};
  localparam logic [NF-1:0] TE[4] = '{21'h1F0004, 21'h00FFFB, 21'h0A5551, 21'h100F0B};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus clock: sample outputs at the falling edge and play the peripheral.
  task automatic tick();
    @(negedge clk);
    if (drv_low) low_run++;
    else if (low_run > 0) begin
      check(drv_high == 1'b1, "R8 recovery high", 32'(drv_high), 1);
      if (bstate == 0) start_len = low_run;
      else if (bstate == 2) stop_len = low_run;
      low_run = 0;
    end
    periph_low = 1'b0;
    if (drv_high && bstate == 0) begin bstate = 1; pos = 0; end
    else if (drv_high && bstate == 2) begin bstate = 0; seq_count++; end
    else if (bstate == 1) begin
      pos++;
      if (pos >= 2 && (pos - 2) % 3 == 0) begin
        int f;
        f = (pos - 2) / 3;
        periph_low = !pattern[f];
        if (f == NF - 1) bstate = 2;
      end
    end
    if (!drv_low && !drv_high && bstate == 0 && mode_q) rel_cnt++;
    else rel_cnt = 0;
    if (kick_en && rel_cnt >= 3) begin periph_low = 1'b1; kick_en = 0; end
  endtask

  task automatic run_seq();
    int s0;
    s0 = seq_count;
    for (int n = 0; n < 400 && seq_count == s0; n++) tick();
    check(seq_count == s0 + 1, "R4 sequence completes", 32'(seq_count), 32'(s0 + 1));
  endtask

  task automatic tracker_clear();
    bstate = 0; pos = 0; low_run = 0; rel_cnt = 0; periph_low = 1'b0;
  endtask

  initial begin
    bit no_drive;
    logic [NF-1:0] saved;
    repeat (3) tick();
    check(!drv_low && !drv_high, "R1 reset releases line", {drv_low, drv_high}, 0);
    check(levels == '0, "R9 reset levels", 32'(levels), 0);
    check(mode_q == 1'b0, "R1 reset mode", 32'(mode_q), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check(!drv_low && !drv_high, "R1 disabled releases line", {drv_low, drv_high}, 0);

    // Table walk: continuous mode, each width code, several wire patterns.
    enable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      width_sel = TW[i];
      pattern = TP[i];
      run_seq();
      check(start_len == TL[i], "R2 start width", 32'(start_len), 32'(TL[i]));
      check(stop_len == 3, "R7 continuous stop", 32'(stop_len), 3);
      check((levels & ~LOWMASK) == (TE[i] & ~LOWMASK), "R5 active-high frames", 32'(levels), 32'(TE[i]));
      check((levels & LOWMASK) == (TE[i] & LOWMASK), "R6 active-low frames", 32'(levels), 32'(TE[i]));
    end

    // Enter quiet mode.
    width_sel = 2'b01; quiet_sel = 1'b1; pattern = 21'h0AAAAA;
    run_seq();
    check(stop_len == 2, "R7 quiet stop", 32'(stop_len), 2);
    tick(); tick();
    check(mode_q == 1'b1, "R7 mode switches to quiet", 32'(mode_q), 1);
    no_drive = 1;
    for (int n = 0; n < 20; n++) begin tick(); if (drv_low || drv_high) no_drive = 0; end
    check(no_drive, "R3 quiet idle released", 32'(no_drive), 1);
    kick_en = 1;
    run_seq();
    check(start_len == 5, "R3 quiet start shortened", 32'(start_len), 5);
    check(levels == 21'h15AAAE, "R5 R6 quiet decode", 32'(levels), 32'h15AAAE);

    // Back to continuous.
    quiet_sel = 1'b0; kick_en = 1; pattern = 21'h123456;
    run_seq();
    check(stop_len == 3, "R7 return to continuous", 32'(stop_len), 3);
    tick(); tick();
    check(mode_q == 1'b0, "R7 mode continuous", 32'(mode_q), 0);
    run_seq();
    check(start_len == 6, "R2 host-started after quiet", 32'(start_len), 6);
    check(levels == 21'h0D3452, "R6 mixed decode", 32'(levels), 32'h0D3452);

    // Abort a quiet-mode cycle mid-data with disable.
    quiet_sel = 1'b1; pattern = 21'h0AAAAA;
    run_seq();
    kick_en = 1;
    run_seq();
    saved = levels;
    pattern = 21'h000000; kick_en = 1;
    for (int n = 0; n < 400 && !(bstate == 1 && pos == 20); n++) tick();
    check(mode_q == 1'b1, "R3 aborted cycle ran in quiet", 32'(mode_q), 1);
    enable = 1'b0; tracker_clear();
    repeat (4) tick();
    check(levels == saved, "R9 partial cycle discarded", 32'(levels), 32'(saved));
    check(!drv_low && !drv_high, "R1 disable releases line", {drv_low, drv_high}, 0);
    check(mode_q == 1'b0, "R1 disable resets mode", 32'(mode_q), 0);
    enable = 1'b1; quiet_sel = 1'b0; kick_en = 0; pattern = 21'h1FFFFF;
    tick(); tick();
    check(drv_low == 1'b1, "R1 host starts on enable", 32'(drv_low), 1);
    run_seq();
    check(start_len == 6, "R1 full-width first start", 32'(start_len), 6);
    check(levels == 21'h00FFFB, "R5 decode after abort", 32'(levels), 32'h00FFFB);

    // Abort with reset mid-data.
    pattern = 21'h155555;
    for (int n = 0; n < 400 && !(bstate == 1 && pos == 30); n++) tick();
    rst_n = 1'b0; tracker_clear();
    tick();
    check(levels == '0, "R9 reset mid-cycle clears", 32'(levels), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R4: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule